// File: doc/BRIEF.md
# Indexed Interrupt Redirection Register Block

This block is the register side and request front end of an I/O interrupt controller serving 24 interrupt input lines. Software reaches it through two locations on a memory-mapped window: an 8-bit index register and a 32-bit data port that exposes whichever internal register the index selects. Behind the data port sit an identification word, a version word, an arbitration identifier and a table of 24 entries. Each entry is 64 bits wide and is split into a low word and a high word.

Each table entry decides how its input line is treated. The entry sets whether the line is masked, whether it is active high or active low, and whether it is edge or level sensitive. Each input passes through a two-stage synchronizer. A qualifying event marks the entry pending. For a level-sensitive entry, the event also sets a remote request flag that only an end-of-interrupt carrying the entry's own vector can clear.

A small dispatch state machine takes the lowest-numbered pending entry. It offers that entry's vector, delivery mode, destination mode and destination on a valid/ready port, and holds the offer until the port accepts it. The machine has two states. In DSP_IDLE it waits; the transition DSP_IDLE→DSP_OFFER fires when any entry is pending and latches the lowest-numbered one. In DSP_OFFER it drives the request; the transition DSP_OFFER→DSP_IDLE fires when msg_ready is high, which also clears that entry's pending flag.

Top module: `ioapic_top`

## Requirements
- R1: A write at bus offset 00h with byte enable 0 set loads the 8-bit index, and a read at offset 00h returns {24'h0, index}. Offset 10h is the data port. Any other offset reads 0, and writes to it change nothing.
- R2: A data-port write takes effect only when all four byte enables (4'hF) are set. A write with any other byte-enable pattern leaves every register unchanged.
- R3: Index 00h holds a 4-bit ID in bits 27:24 that is writable, resets to 0, and has all other bits reading 0. Index 01h reads 0017_0011h and ignores writes. Index 02h reads the arbitration ID (0) in bits 27:24 and ignores writes.
- R4: Entry n's low word is at index 10h+2n and its high word at index 11h+2n. The low word resets to 0001_0000h and the high word to 0. In the high word only bits 31:24 (destination) are stored, and bits 23:0 read 0. Indexes 40h–FFh read 0 and drop writes.
- R5: Low-word layout: bits 7:0 are the vector; bits 10:8 are the delivery mode; bit 11 is the destination mode; bit 12 is pending (read-only); bit 13 set means active low; bit 14 is the remote request flag (read-only); bit 15 set means level sensitive; bit 16 set means masked. Bits 31:17 read 0. Writes to bits 12 and 14 have no effect.
- R6: A masked entry never becomes pending. Edges that arrive while an entry is masked are lost and do not fire after unmasking.
- R7: An unmasked edge entry becomes pending on the transition of its synchronized, polarity-corrected input to the asserted level. The pending bit is readable after the third rising clock edge that samples the new input value.
- R8: An unmasked level entry becomes pending while its input is asserted and its remote request flag is clear. It sets the remote request flag in the same cycle.
- R9: The remote request flag clears only on an end-of-interrupt whose vector equals the entry's bits 7:0. If the input is still asserted afterwards, the entry requests again.
- R10: msg_valid stays high with stable fields until msg_ready is sampled high. Acceptance clears that entry's pending bit.
- R11: When several entries are pending, the lowest-numbered one is offered first.
- R12: The offered message carries the entry's vector, delivery mode (bits 10:8), destination mode (bit 11) and destination (high-word bits 31:24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 8 | Window offset (00h index, 10h data) |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| irq_in | input | 24 | Asynchronous interrupt inputs |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Request offered downstream |
| msg_ready | input | 1 | Downstream accepts the request |
| msg_vector | output | 8 | Vector of the offered entry |
| msg_mode | output | 3 | Delivery mode of the offered entry |
| msg_dest_logical | output | 1 | Destination mode of the offered entry |
| msg_dest | output | 8 | Destination of the offered entry |

## Verification
The hardest state to reach from the ports is a level entry whose remote request flag is set while its input is still asserted. Reaching it requires first configuring an active-low level entry with its line held at the inactive level, then asserting the line, then letting the request be accepted. From that state the bench sends an end-of-interrupt with a non-matching vector and confirms that nothing is requested again. It then sends the matching vector with msg_ready held low, which makes the repeated request visible and held on the port. A behavioural model tracks synchronizer stages, pending flags and the dispatch choice, and it is compared against the message port and the read data on every clock.

// File: rtl/ioapic_pkg.sv
package ioapic_pkg;

    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] IDX_ARB  = 8'h02;
    localparam logic [7:0] IDX_TBL  = 8'h10;
    localparam logic [7:0] VER_CODE = 8'h11;

    localparam int B_DLOG = 11;
    localparam int B_PEND = 12;
    localparam int B_POL  = 13;
    localparam int B_IRR  = 14;
    localparam int B_LVL  = 15;
    localparam int B_MASK = 16;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       act_low;
        logic       dst_logical;
        logic [2:0] mode;
        logic [7:0] vector;
    } rte_cfg_t;

    localparam rte_cfg_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0,
                                       act_low: 1'b0, dst_logical: 1'b0,
                                       mode: 3'b000, vector: 8'h00};

    typedef enum logic {
        DSP_IDLE,
        DSP_OFFER
    } dsp_state_t;

    function automatic logic [31:0] rte_low_word(rte_cfg_t c, logic pend, logic irr);
        logic [31:0] w;
        w          = '0;
        w[7:0]     = c.vector;
        w[10:8]    = c.mode;
        w[B_DLOG]  = c.dst_logical;
        w[B_PEND]  = pend;
        w[B_POL]   = c.act_low;
        w[B_IRR]   = irr;
        w[B_LVL]   = c.level;
        w[B_MASK]  = c.mask;
        return w;
    endfunction

endpackage

// File: rtl/ioapic_regfile.sv
module ioapic_regfile
    import ioapic_pkg::*;
#(
    parameter int         NUM_IRQ = 24,
    parameter int         ADDR_W  = 8,
    parameter logic [3:0] ARB_ID  = 4'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [3:0]              bus_be,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_IRQ-1:0]      st_pend,
    input  logic [NUM_IRQ-1:0]      st_irr,
    output rte_cfg_t [NUM_IRQ-1:0]  cfg
);

    localparam int               TBL_SPAN  = 2 * NUM_IRQ;
    localparam logic [31:0]      VER_WORD  = {8'h00, 8'(NUM_IRQ - 1), 8'h00, VER_CODE};
    localparam logic [ADDR_W-1:0] OFF_INDEX = '0;
    localparam logic [ADDR_W-1:0] OFF_DATA  = ADDR_W'(16);

    logic [7:0]             index_q;
    logic [3:0]             id_q;
    rte_cfg_t [NUM_IRQ-1:0] cfg_q;
    logic                   idx_wr;
    logic                   data_wr;
    logic                   tbl_hit;
    logic                   tbl_hi;
    logic [7:0]             tbl_off;
    logic [6:0]             tbl_ent;
    logic [31:0]            word;
    logic                   unused_wbits;

    assign idx_wr  = bus_sel && bus_we && (bus_addr == OFF_INDEX) && bus_be[0];
    assign data_wr = bus_sel && bus_we && (bus_addr == OFF_DATA) && (bus_be == 4'hF);
    assign tbl_off = index_q - IDX_TBL;
    assign tbl_hit = (index_q >= IDX_TBL) && ({1'b0, tbl_off} < 9'(TBL_SPAN));
    assign tbl_ent = tbl_off[7:1];
    assign tbl_hi  = tbl_off[0];
    assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[B_IRR], bus_wdata[B_PEND]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            id_q    <= '0;
        end else begin
            if (idx_wr) begin
                index_q <= bus_wdata[7:0];
            end
            if (data_wr && (index_q == IDX_ID)) begin
                id_q <= bus_wdata[27:24];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_IRQ; e++) begin
                cfg_q[e] <= RTE_RESET;
            end
        end else if (data_wr && tbl_hit) begin
            for (int e = 0; e < NUM_IRQ; e++) begin
                if (tbl_ent == 7'(e)) begin
                    if (tbl_hi) begin
                        cfg_q[e].dest <= bus_wdata[31:24];
                    end else begin
                        cfg_q[e].vector      <= bus_wdata[7:0];
                        cfg_q[e].mode        <= bus_wdata[10:8];
                        cfg_q[e].dst_logical <= bus_wdata[B_DLOG];
                        cfg_q[e].act_low     <= bus_wdata[B_POL];
                        cfg_q[e].level       <= bus_wdata[B_LVL];
                        cfg_q[e].mask        <= bus_wdata[B_MASK];
                    end
                end
            end
        end
    end

    always_comb begin
        word = '0;
        if (index_q == IDX_ID) begin
            word[27:24] = id_q;
        end else if (index_q == IDX_VER) begin
            word = VER_WORD;
        end else if (index_q == IDX_ARB) begin
            word[27:24] = ARB_ID;
        end else if (tbl_hit) begin
            for (int e = 0; e < NUM_IRQ; e++) begin
                if (tbl_ent == 7'(e)) begin
                    word = tbl_hi ? {cfg_q[e].dest, 24'h000000}
                                  : rte_low_word(cfg_q[e], st_pend[e], st_irr[e]);
                end
            end
        end
    end

    assign bus_rdata = (bus_addr == OFF_INDEX) ? {24'h000000, index_q} :
                       (bus_addr == OFF_DATA)  ? word : '0;
    assign cfg = cfg_q;

    AST_PARTIAL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && (bus_addr == OFF_DATA) && (bus_be != 4'hF)) |=> ($stable(cfg_q) && $stable(id_q))); // R2

endmodule

// File: rtl/ioapic_pin.sv
module ioapic_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_raw,
    input  logic       cfg_mask,
    input  logic       cfg_level,
    input  logic       cfg_act_low,
    input  logic [7:0] cfg_vector,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    input  logic       grant_clr,
    output logic       pend,
    output logic       irr
);

    logic sync1_q;
    logic sync2_q;
    logic seen_q;
    logic asserted;
    logic rise;
    logic lvl_req;
    logic edge_req;
    logic req;
    logic eoi_hit;

    assign asserted = sync2_q ^ cfg_act_low;
    assign rise     = asserted && !seen_q;
    assign lvl_req  = cfg_level && asserted && !irr;
    assign edge_req = !cfg_level && rise;
    assign req      = !cfg_mask && (lvl_req || edge_req);
    assign eoi_hit  = eoi_valid && (eoi_vector == cfg_vector);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            seen_q  <= 1'b0;
            pend    <= 1'b0;
            irr     <= 1'b0;
        end else begin
            sync1_q <= irq_raw;
            sync2_q <= sync1_q;
            seen_q  <= asserted;
            pend    <= (pend && !grant_clr) || req;
            irr     <= (irr && !eoi_hit) || (req && cfg_level);
        end
    end

    AST_MASKED_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(!cfg_mask)); // R6

    AST_IRR_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irr) |-> ($past(cfg_level) && pend)); // R8

    AST_IRR_EOI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irr) |-> $past(eoi_valid && (eoi_vector == cfg_vector))); // R9

endmodule

// File: rtl/ioapic_dispatch.sv
module ioapic_dispatch
    import ioapic_pkg::*;
#(
    parameter int NUM_IRQ = 24,
    localparam int SEL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic               msg_ready,
    output logic               msg_valid,
    output logic [SEL_W-1:0]   sel_q,
    output logic [NUM_IRQ-1:0] grant_clr
);

    localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

    dsp_state_t       state_q;
    dsp_state_t       state_d;
    logic [SEL_W-1:0] sel_d;
    logic [SEL_W-1:0] low_idx;
    logic             any_pend;

    always_comb begin
        low_idx  = '0;
        any_pend = 1'b0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                low_idx  = SEL_W'(i);
                any_pend = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            DSP_IDLE: begin
                if (any_pend) begin
                    state_d = DSP_OFFER;
                    sel_d   = low_idx;
                end
            end
            DSP_OFFER: begin
                if (msg_ready) begin
                    state_d = DSP_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DSP_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        msg_valid = (state_q == DSP_OFFER);
        for (int i = 0; i < NUM_IRQ; i++) begin
            grant_clr[i] = msg_valid && msg_ready && (sel_q == SEL_W'(i));
        end
    end

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(sel_q))); // R10

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (($past(pend_i) & ((ONE << sel_q) - ONE)) == '0)); // R11

endmodule

// File: rtl/ioapic_top.sv
module ioapic_top
    import ioapic_pkg::*;
#(
    parameter int         NUM_IRQ = 24,
    parameter int         ADDR_W  = 8,
    parameter logic [3:0] ARB_ID  = 4'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               eoi_valid,
    input  logic [7:0]         eoi_vector,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [7:0]         msg_vector,
    output logic [2:0]         msg_mode,
    output logic               msg_dest_logical,
    output logic [7:0]         msg_dest
);

    localparam int SEL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    rte_cfg_t [NUM_IRQ-1:0] cfg;
    logic [NUM_IRQ-1:0]     pend;
    logic [NUM_IRQ-1:0]     irr;
    logic [NUM_IRQ-1:0]     grant_clr;
    logic [SEL_W-1:0]       sel;
    logic                   sel_pend;

    ioapic_regfile #(
        .NUM_IRQ (NUM_IRQ),
        .ADDR_W  (ADDR_W),
        .ARB_ID  (ARB_ID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .st_pend   (pend),
        .st_irr    (irr),
        .cfg       (cfg)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pin
        ioapic_pin u_pin (
            .clk         (clk),
            .rst_n       (rst_n),
            .irq_raw     (irq_in[i]),
            .cfg_mask    (cfg[i].mask),
            .cfg_level   (cfg[i].level),
            .cfg_act_low (cfg[i].act_low),
            .cfg_vector  (cfg[i].vector),
            .eoi_valid   (eoi_valid),
            .eoi_vector  (eoi_vector),
            .grant_clr   (grant_clr[i]),
            .pend        (pend[i]),
            .irr         (irr[i])
        );
    end

    ioapic_dispatch #(
        .NUM_IRQ (NUM_IRQ)
    ) u_dsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .sel_q     (sel),
        .grant_clr (grant_clr)
    );

    always_comb begin
        msg_vector       = cfg[0].vector;
        msg_mode         = cfg[0].mode;
        msg_dest_logical = cfg[0].dst_logical;
        msg_dest         = cfg[0].dest;
        sel_pend         = pend[0];
        for (int i = 1; i < NUM_IRQ; i++) begin
            if (sel == SEL_W'(i)) begin
                msg_vector       = cfg[i].vector;
                msg_mode         = cfg[i].mode;
                msg_dest_logical = cfg[i].dst_logical;
                msg_dest         = cfg[i].dest;
                sel_pend         = pend[i];
            end
        end
    end

    AST_OFFER_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> sel_pend); // R10

endmodule

// File: tb/ioapic_top_tb.sv
module ioapic_top_tb;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_dest_logical;
    logic [7:0]  msg_dest;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ioapic_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_dest_logical(msg_dest_logical), .msg_dest(msg_dest)
    );

    // behavioural reference model
    bit [7:0] m_idx;
    bit [3:0] m_id;
    bit [7:0] m_vec [N];
    bit [2:0] m_mode [N];
    bit       m_dm [N];
    bit       m_pol [N];
    bit       m_trig [N];
    bit       m_mask [N];
    bit [7:0] m_dst [N];
    bit       m_s1 [N];
    bit       m_s2 [N];
    bit       m_prev [N];
    bit       m_pend [N];
    bit       m_irr [N];
    int       m_state;
    int       m_sel;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int e;
        if (a == 8'h00) return {24'h0, m_idx};
        if (a != 8'h10) return 32'h0;
        if (m_idx == 8'h00) return {4'h0, m_id, 24'h0};
        if (m_idx == 8'h01) return 32'h0017_0011;
        if (m_idx == 8'h02) return 32'h0;
        if (m_idx < 8'h10 || m_idx >= 8'(16 + 2 * N)) return 32'h0;
        e = (int'(m_idx) - 16) / 2;
        if (m_idx[0]) return {m_dst[e], 24'h0};
        return {15'h0, m_mask[e], m_trig[e], m_irr[e], m_pol[e], m_pend[e],
                m_dm[e], m_mode[e], m_vec[e]};
    endfunction

    always @(posedge clk) begin
        int  old_state;
        int  old_sel;
        int  low;
        bit  any;
        bit  asrt;
        bit  set_p;
        bit  clr_p;
        bit  clr_i;
        int  e;
        if (!rst_n) begin
            m_idx = 0; m_id = 0; m_state = 0; m_sel = 0;
            for (int i = 0; i < N; i++) begin
                m_vec[i] = 0; m_mode[i] = 0; m_dm[i] = 0; m_pol[i] = 0;
                m_trig[i] = 0; m_mask[i] = 1; m_dst[i] = 0; m_s1[i] = 0;
                m_s2[i] = 0; m_prev[i] = 0; m_pend[i] = 0; m_irr[i] = 0;
            end
        end else begin
            old_state = m_state;
            old_sel = m_sel;
            any = 0;
            low = 0;
            for (int i = N - 1; i >= 0; i--) begin
                if (m_pend[i]) begin any = 1; low = i; end
            end
            for (int i = 0; i < N; i++) begin
                asrt = m_s2[i] ^ m_pol[i];
                set_p = 0;
                if (!m_mask[i]) begin
                    if (m_trig[i]) set_p = asrt && !m_irr[i];
                    else set_p = asrt && !m_prev[i];
                end
                clr_p = (old_state == 1) && msg_ready && (old_sel == i);
                clr_i = eoi_valid && (eoi_vector == m_vec[i]);
                m_irr[i] = (m_irr[i] && !clr_i) || (set_p && m_trig[i]);
                m_pend[i] = (m_pend[i] && !clr_p) || set_p;
                m_prev[i] = asrt;
                m_s2[i] = m_s1[i];
                m_s1[i] = irq_in[i];
            end
            if (old_state == 0) begin
                if (any) begin m_state = 1; m_sel = low; end
            end else if (msg_ready) begin
                m_state = 0;
            end
            if (bus_sel && bus_we) begin
                if (bus_addr == 8'h00 && bus_be[0]) begin
                    m_idx = bus_wdata[7:0];
                end else if (bus_addr == 8'h10 && bus_be == 4'hF) begin
                    if (m_idx == 8'h00) begin
                        m_id = bus_wdata[27:24];
                    end else if (m_idx >= 8'h10 && m_idx < 8'(16 + 2 * N)) begin
                        e = (int'(m_idx) - 16) / 2;
                        if (m_idx[0]) begin
                            m_dst[e] = bus_wdata[31:24];
                        end else begin
                            m_vec[e] = bus_wdata[7:0];
                            m_mode[e] = bus_wdata[10:8];
                            m_dm[e] = bus_wdata[11];
                            m_pol[e] = bus_wdata[13];
                            m_trig[e] = bus_wdata[15];
                            m_mask[e] = bus_wdata[16];
                        end
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, sampled away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R7 R10 msg_valid", {31'h0, msg_valid}, (m_state == 1) ? 32'h1 : 32'h0);
            if (m_state == 1) begin
                check("R12 vector", {24'h0, msg_vector}, {24'h0, m_vec[m_sel]});
                check("R12 mode", {29'h0, msg_mode}, {29'h0, m_mode[m_sel]});
                check("R12 dest mode", {31'h0, msg_dest_logical}, {31'h0, m_dm[m_sel]});
                check("R12 dest", {24'h0, msg_dest}, {24'h0, m_dst[m_sel]});
            end
            check("R1 R5 rdata", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
    endtask

    task automatic set_idx(input logic [7:0] i);
        bwrite(8'h00, {24'h0, i}, 4'h1);
    endtask

    task automatic wr_reg(input logic [7:0] i, input logic [31:0] d);
        set_idx(i);
        bwrite(8'h10, d, 4'hF);
    endtask

    task automatic rd_reg(input logic [7:0] i, output logic [31:0] d);
        set_idx(i);
        bus_addr = 8'h10;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        irq_in[7] = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R3 R4: reset values
        check("R10 idle after reset", {31'h0, msg_valid}, 32'h0);
        rd_reg(8'h00, d); check("R3 ID reset", d, 32'h0);
        rd_reg(8'h01, d); check("R3 version", d, 32'h0017_0011);
        rd_reg(8'h02, d); check("R3 arbitration ID", d, 32'h0);
        rd_reg(8'h10, d); check("R4 entry0 low reset", d, 32'h0001_0000);
        rd_reg(8'h11, d); check("R4 entry0 high reset", d, 32'h0);
        rd_reg(8'h3E, d); check("R4 entry23 low reset", d, 32'h0001_0000);
        rd_reg(8'h40, d); check("R4 reserved index", d, 32'h0);

        // R1 index readback and stray offsets
        set_idx(8'h5A);
        bus_addr = 8'h00; #1; check("R1 index readback", bus_rdata, 32'h0000_005A);
        bus_addr = 8'h04; #1; check("R1 stray offset", bus_rdata, 32'h0);

        // R3 ID write, read-only words
        wr_reg(8'h00, 32'hFFFF_FFFF);
        rd_reg(8'h00, d); check("R3 ID field only", d, 32'h0F00_0000);
        wr_reg(8'h01, 32'h0);
        rd_reg(8'h01, d); check("R3 version read-only", d, 32'h0017_0011);
        wr_reg(8'h02, 32'hFFFF_FFFF);
        rd_reg(8'h02, d); check("R3 arbitration read-only", d, 32'h0);
        bwrite(8'h08, 32'h0000_0000, 4'hF);
        rd_reg(8'h00, d); check("R1 write to stray offset dropped", d, 32'h0F00_0000);

        // R2 partial writes
        set_idx(8'h10);
        bwrite(8'h10, 32'h0000_0000, 4'h7);
        rd_reg(8'h10, d); check("R2 partial write ignored", d, 32'h0001_0000);
        set_idx(8'h00);
        bwrite(8'h10, 32'h0000_0000, 4'h8);
        rd_reg(8'h00, d); check("R2 partial ID write ignored", d, 32'h0F00_0000);

        // R4 reserved index writes dropped
        wr_reg(8'h50, 32'hFFFF_FFFF);
        rd_reg(8'h50, d); check("R4 reserved write dropped", d, 32'h0);

        // entry 3: edge, NMI, logical, dest A5; R5 read-only bits
        wr_reg(8'h17, 32'hA5FF_FFFF);
        rd_reg(8'h17, d); check("R4 high word reserved bits", d, 32'hA500_0000);
        wr_reg(8'h16, 32'h0000_5C33);
        rd_reg(8'h16, d); check("R5 status bits ignore writes", d, 32'h0000_0C33);

        // R7 R10: edge request held while ready low
        msg_ready = 1'b0;
        irq_in[3] = 1'b1;
        tick(3);
        irq_in[3] = 1'b0;
        tick(4);
        rd_reg(8'h16, d); check("R7 pending visible", d, 32'h0000_1C33);
        check("R10 offer raised", {31'h0, msg_valid}, 32'h1);
        check("R12 vector of entry 3", {24'h0, msg_vector}, 32'h33);
        tick(3);
        check("R10 offer held", {31'h0, msg_valid}, 32'h1);
        msg_ready = 1'b1;
        tick(2);
        rd_reg(8'h16, d); check("R10 accept clears pending", d, 32'h0000_0C33);

        // R6 masked edge is lost
        irq_in[5] = 1'b1;
        tick(3);
        irq_in[5] = 1'b0;
        tick(5);
        check("R6 masked no offer", {31'h0, msg_valid}, 32'h0);
        rd_reg(8'h1A, d); check("R6 masked not pending", d, 32'h0001_0000);
        wr_reg(8'h1A, 32'h0000_0055);
        tick(6);
        check("R6 lost edge stays lost", {31'h0, msg_valid}, 32'h0);

        // R8 R9: active-low level entry 7
        wr_reg(8'h1F, 32'h3C00_0000);
        wr_reg(8'h1E, 32'h0000_A077);
        tick(4);
        check("R8 deasserted level idle", {31'h0, msg_valid}, 32'h0);
        irq_in[7] = 1'b0;
        tick(8);
        rd_reg(8'h1E, d); check("R8 IRR set after delivery", d, 32'h0000_E077);
        tick(5);
        check("R8 no repeat while IRR set", {31'h0, msg_valid}, 32'h0);
        eoi_valid = 1'b1; eoi_vector = 8'h78;
        tick(1);
        eoi_valid = 1'b0;
        tick(4);
        rd_reg(8'h1E, d); check("R9 wrong vector keeps IRR", d, 32'h0000_E077);
        check("R9 no offer on wrong vector", {31'h0, msg_valid}, 32'h0);
        msg_ready = 1'b0;
        eoi_valid = 1'b1; eoi_vector = 8'h77;
        tick(1);
        eoi_valid = 1'b0;
        tick(4);
        check("R9 re-request after EOI", {31'h0, msg_valid}, 32'h1);
        check("R12 vector of entry 7", {24'h0, msg_vector}, 32'h77);
        check("R12 dest of entry 7", {24'h0, msg_dest}, 32'h3C);
        msg_ready = 1'b1;
        irq_in[7] = 1'b1;
        tick(6);
        eoi_valid = 1'b1; eoi_vector = 8'h77;
        tick(1);
        eoi_valid = 1'b0;
        tick(4);
        rd_reg(8'h1E, d); check("R9 EOI clears IRR", d, 32'h0000_A077);

        // R11 priority between entries 2 and 9
        wr_reg(8'h14, 32'h0000_0122);
        wr_reg(8'h22, 32'h0000_0799);
        msg_ready = 1'b0;
        irq_in[2] = 1'b1; irq_in[9] = 1'b1;
        tick(3);
        irq_in[2] = 1'b0; irq_in[9] = 1'b0;
        tick(4);
        check("R11 lowest first", {24'h0, msg_vector}, 32'h22);
        check("R12 lowest-priority mode", {29'h0, msg_mode}, 32'h1);
        msg_ready = 1'b1;
        tick(1);
        msg_ready = 1'b0;
        tick(2);
        check("R11 next entry offered", {24'h0, msg_vector}, 32'h99);
        check("R12 ExtINT mode", {29'h0, msg_mode}, 32'h7);
        msg_ready = 1'b1;
        tick(4);
        check("R10 all drained", {31'h0, msg_valid}, 32'h0);

        finish_run();
    end

endmodule